// File: doc/BRIEF.md
# Memory Access Alignment Exception Detector

This block sits beside the load/store decode path. For each decoded memory operation it takes the operation class, the low bits of the effective address, the operand size, the segment and boundary flags, the storage attributes and the current byte order. From these it decides whether the access must trap as an alignment exception.

A request is registered one cycle after a valid strobe. It carries the fixed exception vector offset and a cause code. The cause code names the first matching rule in a fixed priority order.

The address calculation and the exception dispatch that consumes the request are outside this block. The decision depends on more than the low address bits against the operand size. It also depends on the instruction class, the storage attributes and the endian mode.

Top module: `align_exc_detect`

## Requirements
- R1: While rst_ni is low, exc_o, cause_o and vec_o are all zero.
- R2: Outputs are registered: a strobe on valid_i is reflected one clock later. A cycle with valid_i low yields exc_o=0, cause_o=0 and vec_o=0 on the next clock, whatever the other inputs are.
- R3: Floating-point class (op_class_i=1) with addr_ofs_i[1:0] non-zero raises the exception with cause 1.
- R4: Multiple class (op_class_i=2) with addr_ofs_i[1:0] non-zero raises cause 2. Reserve/conditional class (op_class_i=3) raises cause 2 when the address is not a multiple of its operand size. The operand size is 2**size_i bytes, and only addr_ofs_i[2:0] is examined.
- R5: Floating-point class with dir_seg_i=1 raises cause 3.
- R6: Ordinary (0), floating-point (1), multiple (2) or string (4) class with cross_dseg_i=1 or cross_prot_i=1 raises cause 4.
- R7: External-control word class (op_class_i=5) with addr_ofs_i[1:0] non-zero raises cause 5.
- R8: With little_end_i=1, every multiple (2) or string (4) class access raises cause 6.
- R9: Cache-block-zero class (op_class_i=6) with wr_thru_i=1 or cache_inh_i=1 raises cause 7.
- R10: Ordinary class without a boundary crossing, and the unused class code 7, never raise the exception.
- R11: When several rules match, cause_o is the lowest matching cause number. exc_o is 1 exactly when cause_o is non-zero.
- R12: vec_o is 0x00600 while exc_o is 1 and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_class_i | input | 3 | Operation class: 0 ordinary, 1 float, 2 multiple, 3 reserve/conditional, 4 string, 5 external-control word, 6 cache-block zero, 7 unused |
| addr_ofs_i | input | 3 | Effective address bits [2:0] |
| size_i | input | 2 | log2 of operand size in bytes |
| dir_seg_i | input | 1 | Target is a direct-store segment |
| cross_dseg_i | input | 1 | Access crosses into a direct-store segment |
| cross_prot_i | input | 1 | Access crosses a protection boundary |
| wr_thru_i | input | 1 | Write-through-required attribute |
| cache_inh_i | input | 1 | Caching-inhibited attribute |
| little_end_i | input | 1 | Little-endian mode |
| exc_o | output | 1 | Registered alignment exception request |
| vec_o | output | 20 | Vector offset while requesting |
| cause_o | output | 3 | Cause code, 0 when idle |

## Verification
Several rules can match the same operation in one cycle. Examples are a misaligned floating-point access into a direct-store segment, and a string access in little-endian mode that also crosses a protection boundary. In both cases the priority encoder alone picks the reported cause.

Directed vectors set two or three matching conditions together. The random vectors enable every flag often enough that overlaps happen throughout the run. Each result is judged against a bench model that walks the rules in priority order and takes the first match.

// File: rtl/align_exc_pkg.sv
package align_exc_pkg;
  localparam int OFS_W   = 3;
  localparam int RULE_N  = 7;
  localparam int CAUSE_W = $clog2(RULE_N + 1);

  typedef enum logic [2:0] {
    OP_ORD   = 3'd0,
    OP_FP    = 3'd1,
    OP_MULT  = 3'd2,
    OP_RSV   = 3'd3,
    OP_STR   = 3'd4,
    OP_ECW   = 3'd5,
    OP_BZERO = 3'd6,
    OP_NONE  = 3'd7
  } op_class_e;

  // cause code n corresponds to rule index n-1
  typedef enum logic [CAUSE_W-1:0] {
    CA_NONE     = 3'd0,
    CA_FP_MIS   = 3'd1,
    CA_WORD_MIS = 3'd2,
    CA_FP_DSEG  = 3'd3,
    CA_CROSS    = 3'd4,
    CA_ECW_MIS  = 3'd5,
    CA_LE_MULTI = 3'd6,
    CA_BZ_ATTR  = 3'd7
  } cause_e;
endpackage

// File: rtl/align_rule_eval.sv
module align_rule_eval
  import align_exc_pkg::*;
(
  input  logic [2:0]       op_class_i,
  input  logic [OFS_W-1:0] addr_ofs_i,
  input  logic [1:0]       size_i,
  input  logic             dir_seg_i,
  input  logic             cross_dseg_i,
  input  logic             cross_prot_i,
  input  logic             wr_thru_i,
  input  logic             cache_inh_i,
  input  logic             little_end_i,
  output logic [RULE_N-1:0] hit_o
);
  op_class_e  op;
  logic       word_mis;
  logic       nat_mis;
  logic [3:0] nat_span;
  logic       is_fp, is_mult, is_rsv, is_str, is_ecw, is_bz, is_ord;

  assign op       = op_class_e'(op_class_i);
  assign is_ord   = (op == OP_ORD);
  assign is_fp    = (op == OP_FP);
  assign is_mult  = (op == OP_MULT);
  assign is_rsv   = (op == OP_RSV);
  assign is_str   = (op == OP_STR);
  assign is_ecw   = (op == OP_ECW);
  assign is_bz    = (op == OP_BZERO);

  assign word_mis = |addr_ofs_i[1:0];
  // natural alignment mask for 1/2/4/8-byte operands
  assign nat_span = (4'd1 << size_i) - 4'd1;
  assign nat_mis  = |(addr_ofs_i & nat_span[OFS_W-1:0]);

  always_comb begin
    hit_o    = '0;
    hit_o[0] = is_fp && word_mis;
    hit_o[1] = (is_mult && word_mis) || (is_rsv && nat_mis);
    hit_o[2] = is_fp && dir_seg_i;
    hit_o[3] = (is_ord || is_fp || is_mult || is_str) && (cross_dseg_i || cross_prot_i);
    hit_o[4] = is_ecw && word_mis;
    hit_o[5] = little_end_i && (is_mult || is_str);
    hit_o[6] = is_bz && (wr_thru_i || cache_inh_i);
  end
endmodule

// File: rtl/align_prio_enc.sv
module align_prio_enc #(
  parameter int N = 7,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] hit_i,
  output logic [W-1:0] code_o
);
  // lowest index wins; code = index + 1, 0 means no hit
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) code_o = W'(i + 1);
    end
  end
endmodule

// File: rtl/align_exc_detect.sv
module align_exc_detect
  import align_exc_pkg::*;
#(
  parameter int               VEC_W   = 20,
  parameter logic [VEC_W-1:0] VEC_OFF = VEC_W'(20'h00600)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         op_class_i,
  input  logic [OFS_W-1:0]   addr_ofs_i,
  input  logic [1:0]         size_i,
  input  logic               dir_seg_i,
  input  logic               cross_dseg_i,
  input  logic               cross_prot_i,
  input  logic               wr_thru_i,
  input  logic               cache_inh_i,
  input  logic               little_end_i,
  output logic               exc_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [RULE_N-1:0]  hit;
  logic [CAUSE_W-1:0] code;

  align_rule_eval u_rules (
    .op_class_i   (op_class_i),
    .addr_ofs_i   (addr_ofs_i),
    .size_i       (size_i),
    .dir_seg_i    (dir_seg_i),
    .cross_dseg_i (cross_dseg_i),
    .cross_prot_i (cross_prot_i),
    .wr_thru_i    (wr_thru_i),
    .cache_inh_i  (cache_inh_i),
    .little_end_i (little_end_i),
    .hit_o        (hit)
  );

  align_prio_enc #(.N(RULE_N), .W(CAUSE_W)) u_prio (
    .hit_i  (hit),
    .code_o (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o   <= 1'b0;
      cause_o <= '0;
      vec_o   <= '0;
    end else if (valid_i && (code != '0)) begin
      exc_o   <= 1'b1;
      cause_o <= code;
      vec_o   <= VEC_OFF;
    end else begin
      exc_o   <= 1'b0;
      cause_o <= '0;
      vec_o   <= '0;
    end
  end
endmodule

// File: rtl/align_exc_chk.sv
module align_exc_chk
  import align_exc_pkg::*;
#(
  parameter int VEC_W = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [2:0]         op_class_i,
  input logic [OFS_W-1:0]   addr_ofs_i,
  input logic               dir_seg_i,
  input logic               cross_dseg_i,
  input logic               cross_prot_i,
  input logic               wr_thru_i,
  input logic               cache_inh_i,
  input logic               little_end_i,
  input logic               exc_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [CAUSE_W-1:0] cause_o
);
  p_idle_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!exc_o && cause_o == '0));

  p_fp_mis_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_class_i == 3'd1 && addr_ofs_i[1:0] != 2'b00) |=> (exc_o && cause_o == 3'd1));

  p_le_multi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && little_end_i && (op_class_i == 3'd2 || op_class_i == 3'd4)) |=> exc_o);

  p_bzero_attr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_class_i == 3'd6 && (wr_thru_i || cache_inh_i)) |=> (exc_o && cause_o == 3'd7));

  p_plain_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_class_i == 3'd7 || (op_class_i == 3'd0 && !cross_dseg_i && !cross_prot_i)))
      |=> !exc_o);

  p_cause_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o == (cause_o != '0));

  p_vector_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (vec_o == VEC_W'(20'h00600)));

  p_ds_fp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_class_i == 3'd1 && dir_seg_i) |=> (exc_o && cause_o <= 3'd3));

  // R6 and R7 are covered by the bench model
endmodule

bind align_exc_detect align_exc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op_class_i   (op_class_i),
  .addr_ofs_i   (addr_ofs_i),
  .dir_seg_i    (dir_seg_i),
  .cross_dseg_i (cross_dseg_i),
  .cross_prot_i (cross_prot_i),
  .wr_thru_i    (wr_thru_i),
  .cache_inh_i  (cache_inh_i),
  .little_end_i (little_end_i),
  .exc_o        (exc_o),
  .vec_o        (vec_o),
  .cause_o      (cause_o)
);

// File: tb/align_exc_detect_tb.sv
module align_exc_detect_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_class_i = '0;
  logic [2:0]  addr_ofs_i = '0;
  logic [1:0]  size_i = '0;
  logic        dir_seg_i = 1'b0, cross_dseg_i = 1'b0, cross_prot_i = 1'b0;
  logic        wr_thru_i = 1'b0, cache_inh_i = 1'b0, little_end_i = 1'b0;
  logic        exc_o;
  logic [19:0] vec_o;
  logic [2:0]  cause_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  align_exc_detect u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_class_i(op_class_i),
    .addr_ofs_i(addr_ofs_i), .size_i(size_i), .dir_seg_i(dir_seg_i),
    .cross_dseg_i(cross_dseg_i), .cross_prot_i(cross_prot_i), .wr_thru_i(wr_thru_i),
    .cache_inh_i(cache_inh_i), .little_end_i(little_end_i),
    .exc_o(exc_o), .vec_o(vec_o), .cause_o(cause_o)
  );

  function automatic logic [2:0] model(input logic v, input logic [2:0] op, input logic [2:0] ofs,
      input logic [1:0] sz, input logic ds, input logic cd, input logic cp,
      input logic wt, input logic ci, input logic le);
    logic mis4 = (ofs % 4) != 0;
    logic misn = (ofs % (3'd1 << sz)) != 0;
    if (!v) return 3'd0;
    if (op == 1 && mis4) return 3'd1;
    if ((op == 2 && mis4) || (op == 3 && misn)) return 3'd2;
    if (op == 1 && ds) return 3'd3;
    if ((op == 0 || op == 1 || op == 2 || op == 4) && (cd || cp)) return 3'd4;
    if (op == 5 && mis4) return 3'd5;
    if (le && (op == 2 || op == 4)) return 3'd6;
    if (op == 6 && (wt || ci)) return 3'd7;
    return 3'd0;
  endfunction

  function automatic string req_of(input logic [2:0] c, input logic [2:0] op);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return (op == 0 || op == 7) ? "R10" : "R2";
    endcase
  endfunction

  // drive at a negedge, check at the following negedge
  task automatic apply(input logic v, input logic [2:0] op, input logic [2:0] ofs,
      input logic [1:0] sz, input logic ds, input logic cd, input logic cp,
      input logic wt, input logic ci, input logic le, input string tag);
    logic [2:0]  ec;
    logic [19:0] ev;
    valid_i = v; op_class_i = op; addr_ofs_i = ofs; size_i = sz;
    dir_seg_i = ds; cross_dseg_i = cd; cross_prot_i = cp;
    wr_thru_i = wt; cache_inh_i = ci; little_end_i = le;
    ec = model(v, op, ofs, sz, ds, cd, cp, wt, ci, le);
    ev = (ec != 0) ? 20'h00600 : 20'h0;
    @(negedge clk);
    n_vec++;
    if (exc_o !== (ec != 0) || cause_o !== ec || vec_o !== ev) begin
      n_bad++;
      $display("FAIL %s/%s: exc=%0b cause=%0d vec=%h expected exc=%0b cause=%0d vec=%h (R12 vec)",
               tag, req_of(ec, op), exc_o, cause_o, vec_o, ec != 0, ec, ev);
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    #5;
    n_vec++; // R1 reset state
    if (exc_o !== 1'b0 || cause_o !== 3'd0 || vec_o !== 20'h0) begin
      n_bad++;
      $display("FAIL R1: exc=%0b cause=%0d vec=%h expected 0 0 0", exc_o, cause_o, vec_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    apply(1, 3'd1, 3'd2, 2'd3, 0, 0, 0, 0, 0, 0, "R3 fp misaligned");
    apply(1, 3'd1, 3'd4, 2'd3, 0, 0, 0, 0, 0, 0, "R3 fp word aligned");
    apply(0, 3'd1, 3'd1, 2'd2, 1, 1, 1, 1, 1, 1, "R2 no strobe");
    apply(1, 3'd2, 3'd3, 2'd2, 0, 0, 0, 0, 0, 0, "R4 multiple misaligned");
    apply(1, 3'd3, 3'd4, 2'd3, 0, 0, 0, 0, 0, 0, "R4 reserve dword at ofs 4");
    apply(1, 3'd3, 3'd4, 2'd2, 0, 0, 0, 0, 0, 0, "R4 reserve word aligned");
    apply(1, 3'd1, 3'd0, 2'd2, 1, 0, 0, 0, 0, 0, "R5 fp direct-store");
    apply(1, 3'd4, 3'd1, 2'd0, 0, 0, 1, 0, 0, 0, "R6 string prot cross");
    apply(1, 3'd0, 3'd3, 2'd2, 0, 1, 0, 0, 0, 0, "R6 ordinary dseg cross");
    apply(1, 3'd5, 3'd6, 2'd2, 0, 0, 0, 0, 0, 0, "R7 ecw misaligned");
    apply(1, 3'd4, 3'd0, 2'd0, 0, 0, 0, 0, 0, 1, "R8 LE string");
    apply(1, 3'd6, 3'd0, 2'd3, 0, 0, 0, 0, 1, 0, "R9 bzero inhibited");
    apply(1, 3'd6, 3'd0, 2'd3, 0, 0, 0, 1, 0, 0, "R9 bzero write-through");
    apply(1, 3'd0, 3'd7, 2'd3, 1, 0, 0, 1, 1, 1, "R10 ordinary misaligned");
    apply(1, 3'd7, 3'd3, 2'd3, 1, 1, 1, 1, 1, 1, "R10 unused class");
    apply(1, 3'd1, 3'd1, 2'd3, 1, 1, 0, 0, 0, 0, "R11 fp mis+ds+cross");
    apply(1, 3'd4, 3'd0, 2'd0, 0, 0, 1, 0, 0, 1, "R11 LE string + cross");
    apply(1, 3'd2, 3'd2, 2'd2, 0, 1, 0, 0, 0, 1, "R11 multiple mis+cross+LE");

    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 8) != 0, 3'($urandom % 8), 3'($urandom % 8), 2'($urandom % 4),
            ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
            ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0, "R11 random");
    end
    apply(0, 3'd0, 3'd0, 2'd0, 0, 0, 0, 0, 0, 0, "R2 drain");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule